// File: doc/BRIEF.md
# Shared Sense-Amp Bank Activation Tracker

This block keeps track of which banks in a multi-bank DRAM core currently hold an open row. It also records which row each open bank holds. The core is split into two halves of sixteen banks. Inside a half, each bank shares a sense-amp set with the bank next to it. Two banks that share a set must never be open together. The banks at the outer ends of each half have no partner on their outer side. This means banks 15 and 16 are not neighbours, and banks 0 and 31 each have only one neighbour.

The block receives row commands that have already been decoded. A row command is either an activate, which carries a bank and a row, or a precharge, which carries a bank. The block also receives two kinds of precharge from the column side: a read or write that ends with an automatic precharge, and an extended-operation precharge. Every command carries a device field. The block acts on a command only when that field matches its own device ID.

An activate that breaks the sharing rule is refused. A refused activate leaves the bank state unchanged and raises a sticky conflict flag. All state is held in registers, so the effect of a command appears one clock after the edge on which the command is sampled.

Top module: `bank_act_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, every bank is closed, every recorded row is zero and `conflict` is low.
- R2: A matching activate (`row_valid`=1, `row_op`=1) to a closed bank whose sharing neighbours are all closed sets `bank_open[bank]` and stores `row_addr` in `open_rows[bank*9 +: 9]`. Both take effect one clock later.
- R3: No two banks that share a sense-amp set are ever open at the same time. Bank i shares with bank i+1 unless i is 15 or 31, so banks 15 and 16 can be open together, as can banks 0 and 31.
- R4: A matching activate to a bank that is already open, or to a bank with an open sharing neighbour, sets `conflict`. In that case `bank_open` and `open_rows` do not change.
- R5: A matching row precharge (`row_valid`=1, `row_op`=0) closes the bank and clears its recorded row to zero.
- R6: A matching column auto-precharge (`col_autopre`=1) closes the bank selected by `col_bank` and clears its recorded row.
- R7: A matching extended-operation precharge (`col_xpre`=1) closes the bank selected by `col_bank` and clears its recorded row.
- R8: A row or column command whose device field differs from `dev_id` has no effect on any output.
- R9: Once `conflict` is set, it stays high until reset, whatever commands follow.
- R10: When a column precharge and a row activate arrive in the same cycle, the activate is judged against the bank state from before that cycle, and the precharge is always carried out.
- R11: A precharge to a bank that is already closed changes nothing and does not set `conflict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_id | input | 5 | Device ID of this core |
| row_valid | input | 1 | A row command is present |
| row_op | input | 1 | 1 = activate, 0 = precharge |
| row_dev | input | 5 | Device field of the row command |
| row_bank | input | 5 | Bank of the row command |
| row_addr | input | 9 | Row to open on an activate |
| col_autopre | input | 1 | Column command with automatic precharge |
| col_xpre | input | 1 | Extended-operation precharge |
| col_dev | input | 5 | Device field of the column command |
| col_bank | input | 5 | Bank of the column command |
| bank_open | output | 32 | One open flag per bank |
| open_rows | output | 288 | Recorded row per bank, 9 bits each, bank 0 in the lowest bits |
| conflict | output | 1 | Sticky flag for a refused activate |

## Verification
Two functions can fall in the same cycle: a column precharge, which closes a bank, and a row activate, which is checked against the sharing rule. The bench drives both in one cycle in two arrangements. In the first, the activate targets the neighbour of the bank being closed. It must be refused with `conflict` set, while the neighbour still closes. In the second, the activate targets an unrelated bank. It must succeed while the other bank closes.

// File: rtl/bank_act_tracker.sv
module bank_act_tracker #(
  parameter int NUM_BANKS      = 32,
  parameter int BANKS_PER_HALF = 16,
  parameter int ROW_W          = 9,
  parameter int DEV_W          = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DEV_W-1:0]           dev_id,
  input  logic                       row_valid,
  input  logic                       row_op,
  input  logic [DEV_W-1:0]           row_dev,
  input  logic [$clog2(NUM_BANKS)-1:0] row_bank,
  input  logic [ROW_W-1:0]           row_addr,
  input  logic                       col_autopre,
  input  logic                       col_xpre,
  input  logic [DEV_W-1:0]           col_dev,
  input  logic [$clog2(NUM_BANKS)-1:0] col_bank,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       conflict
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [ROW_W-1:0]     rows_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] share_up;
  logic [NUM_BANKS-1:0] nbr_open;
  logic [NUM_BANKS-1:0] close_mask;

  wire row_hit = row_valid && (row_dev == dev_id);
  wire col_hit = (col_autopre || col_xpre) && (col_dev == dev_id);
  wire act_req = row_hit && row_op;
  wire blocked = open_q[row_bank] || nbr_open[row_bank];
  wire act_ok  = act_req && !blocked;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    if (i < NUM_BANKS - 1) begin : g_up
      assign share_up[i] = (i % BANKS_PER_HALF) != (BANKS_PER_HALF - 1);
    end else begin : g_last
      assign share_up[i] = 1'b0;
    end

    if (i == 0) begin : g_first
      assign nbr_open[i] = share_up[i] && open_q[i+1];
    end else if (i == NUM_BANKS - 1) begin : g_end
      assign nbr_open[i] = share_up[i-1] && open_q[i-1];
    end else begin : g_mid
      assign nbr_open[i] = (share_up[i-1] && open_q[i-1]) || (share_up[i] && open_q[i+1]);
    end

    assign close_mask[i] = (row_hit && !row_op && row_bank == BANK_W'(i)) ||
                           (col_hit && col_bank == BANK_W'(i));
    assign open_rows[i*ROW_W +: ROW_W] = rows_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[i] <= 1'b0;
        rows_q[i] <= '0;
      end else if (act_ok && row_bank == BANK_W'(i)) begin
        open_q[i] <= 1'b1;
        rows_q[i] <= row_addr;
      end else if (close_mask[i]) begin
        open_q[i] <= 1'b0;
        rows_q[i] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict <= 1'b0;
    else if (act_req && blocked) conflict <= 1'b1;
  end

  assign bank_open = open_q;

  assert_no_shared_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((open_q & (open_q >> 1) & share_up) == '0));

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_ok |=> (open_q[$past(row_bank)] && rows_q[$past(row_bank)] == $past(row_addr)));

  assert_refused_keeps_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req && blocked && !col_hit) |=> ($stable(open_q) && conflict));

  assert_conflict_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> conflict);

  assert_foreign_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_hit && !col_hit) |=> ($stable(open_q) && $stable(open_rows)));

  assert_col_pre_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_hit && !(act_ok && row_bank == col_bank)) |=> !open_q[$past(col_bank)]);
endmodule

// File: tb/bank_act_tracker_test.sv
module bank_act_tracker_test;
  localparam logic [4:0] ID = 5'h0B;
  localparam logic [4:0] OTHER = 5'h03;

  logic clk = 0, rst_n = 0;
  logic [4:0] dev_id = ID;
  logic row_valid = 0, row_op = 0;
  logic [4:0] row_dev = 0, row_bank = 0;
  logic [8:0] row_addr = 0;
  logic col_autopre = 0, col_xpre = 0;
  logic [4:0] col_dev = 0, col_bank = 0;
  logic [31:0] bank_open;
  logic [287:0] open_rows;
  logic conflict;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bank_act_tracker uut (.clk(clk), .rst_n(rst_n), .dev_id(dev_id), .row_valid(row_valid),
    .row_op(row_op), .row_dev(row_dev), .row_bank(row_bank), .row_addr(row_addr),
    .col_autopre(col_autopre), .col_xpre(col_xpre), .col_dev(col_dev), .col_bank(col_bank),
    .bank_open(bank_open), .open_rows(open_rows), .conflict(conflict));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] row_of(input int b);
    return 32'(open_rows[b*9 +: 9]);
  endfunction

  task automatic idle();
    row_valid = 0; row_op = 0; col_autopre = 0; col_xpre = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic set_row(input logic op, input logic [4:0] dev, input logic [4:0] b, input logic [8:0] r);
    row_valid = 1; row_op = op; row_dev = dev; row_bank = b; row_addr = r;
  endtask

  task automatic set_col(input logic xp, input logic [4:0] dev, input logic [4:0] b);
    col_autopre = !xp; col_xpre = xp; col_dev = dev; col_bank = b;
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    rst_n = 0;
    @(negedge clk);
    chk("R1 open in reset", bank_open, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 open", bank_open, 0);
    chk("R1 conflict", 32'(conflict), 0);
    chk("R1 rows", 32'(|open_rows), 0);
  endtask

  task automatic t_activate_precharge();
    set_row(1, ID, 3, 9'h1A5); step();
    chk("R2 open", bank_open, 32'h8);
    chk("R2 row", row_of(3), 32'h1A5);
    set_row(1, ID, 4, 9'h011); step();
    chk("R4 neighbour conflict", 32'(conflict), 1);
    chk("R4 state kept", bank_open, 32'h8);
    chk("R4 row4 untouched", row_of(4), 0);
    set_row(0, ID, 3, 0); step();
    chk("R5 closed", bank_open, 0);
    chk("R5 row cleared", row_of(3), 0);
    chk("R9 sticky", 32'(conflict), 1);
    set_row(1, ID, 9, 9'h002); step();
    chk("R9 sticky after good act", 32'(conflict), 1);
    do_reset();
  endtask

  task automatic t_edges();
    set_row(1, ID, 15, 9'h0F0); step();
    set_row(1, ID, 16, 9'h10F); step();
    set_row(1, ID, 0, 9'h001); step();
    set_row(1, ID, 31, 9'h1FF); step();
    chk("R3 edges both open", bank_open, 32'h8001_8001);
    chk("R3 no conflict at edges", 32'(conflict), 0);
    set_row(1, ID, 1, 9'h005); step();
    chk("R3 bank1 refused", bank_open, 32'h8001_8001);
    chk("R4 conflict bank1", 32'(conflict), 1);
    do_reset();
    set_row(1, ID, 15, 9'h0F0); step();
    set_row(1, ID, 15, 9'h033); step();
    chk("R4 reopen conflict", 32'(conflict), 1);
    chk("R4 row kept", row_of(15), 32'h0F0);
    do_reset();
  endtask

  task automatic t_col_pre();
    set_row(1, ID, 15, 9'h0AA); step();
    set_row(1, ID, 16, 9'h055); step();
    set_col(0, ID, 15); step();
    chk("R6 autopre closes", bank_open, 32'h0001_0000);
    chk("R6 row cleared", row_of(15), 0);
    set_col(1, ID, 16); step();
    chk("R7 xpre closes", bank_open, 0);
    chk("R7 row cleared", row_of(16), 0);
    set_row(0, ID, 7, 0); step();
    set_col(1, ID, 8); step();
    chk("R11 no change", bank_open, 0);
    chk("R11 no conflict", 32'(conflict), 0);
  endtask

  task automatic t_foreign();
    set_row(1, ID, 20, 9'h123); step();
    set_row(1, OTHER, 5, 9'h077); step();
    chk("R8 foreign act", bank_open, 32'h0010_0000);
    set_row(1, OTHER, 20, 9'h077); step();
    chk("R8 foreign no conflict", 32'(conflict), 0);
    set_row(0, OTHER, 20, 0); step();
    set_col(0, OTHER, 20); step();
    set_col(1, OTHER, 20); step();
    chk("R8 foreign pre", bank_open, 32'h0010_0000);
    chk("R8 row kept", row_of(20), 32'h123);
    do_reset();
  endtask

  task automatic t_same_cycle();
    set_row(1, ID, 0, 9'h00C); step();
    set_col(1, ID, 0); set_row(1, ID, 1, 9'h0DD); step();
    chk("R10 pre applied, act refused", bank_open, 0);
    chk("R10 conflict", 32'(conflict), 1);
    do_reset();
    set_row(1, ID, 0, 9'h00C); step();
    set_col(0, ID, 0); set_row(1, ID, 5, 9'h0EE); step();
    chk("R10 both applied", bank_open, 32'h20);
    chk("R10 row5", row_of(5), 32'h0EE);
    chk("R10 no conflict", 32'(conflict), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_activate_precharge();
    t_edges();
    t_col_pre();
    t_foreign();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule